// File: doc/BRIEF.md
# Descriptor-List Cyclic DMA Reader

This block is a single-channel read engine that streams a cyclic buffer out to a
ready/valid output port. The buffer is described by a list of descriptors in
memory. Each descriptor is 16 bytes long and names one fragment of the buffer.
The engine fetches a descriptor, reads that fragment one 32-bit word at a time
through a simple request/response memory port, and pushes each word into a
small internal FIFO that drives the output stream. When it passes the last
listed descriptor it goes back to the first one, so the buffer is read around
and around for as long as the engine runs.

Software sets the engine up through eight word-addressed registers. These hold
the list base, the ring length, the last descriptor index, a control word
(run bit, three interrupt enables and a 4-bit stream tag) and a write-1-to-clear
status word. A producer can keep the engine behind its own write pointer with a
position limit. When the limit is enabled, the engine reads up to the limit
offset inside the ring and waits there. It continues when software writes the
limit register again. Completion is reported only when a whole descriptor has
been read, never for part of one.

Top module: `dlc_reader`

## Requirements
- R1: Descriptor `i` is read as four words at list base + 16*i: fragment address low, fragment address high, length in bytes, flags (bit 0 requests a completion flag). The fragment's words are then read at ascending addresses, with only one memory request outstanding, and leave the output in the same order.
- R2: After the descriptor whose index equals the last-index register, the engine goes on with descriptor 0.
- R3: A ring position advances by 4 bytes for each data word. It returns to 0 when it reaches the ring length register.
- R4: While limit-enable (register 7 bit 0) is set, the engine issues no data read once the position has reached the limit value (limit equal to the ring length means offset 0). The next write to the limit register, register 6, releases it. Writing the position the engine already holds releases exactly one full lap.
- R5: Status bit 0 (buffer complete) sets when the last word of a descriptor with flags bit 0 set returns. With the output ready and the FIFO empty, the interrupt rises in the cycle that word first appears at the output.
- R6: Status (register 1, bits 0/1/2 = complete / FIFO error / descriptor error) is write-1-to-clear. The interrupt is high exactly when a status bit is set and its enable is set (control bits 1/2/3).
- R7: A descriptor length of zero, or a memory response with the error flag, sets status bit 2 and clears the run bit. No further reads are issued after that.
- R8: If a data word returns while the FIFO is full and the output is not ready, the word is dropped and status bit 1 sets. Words already queued leave unchanged.
- R9: Clearing the run bit (control bit 0) lets the read in flight finish and then stops all requests. Setting run while the engine is idle starts again at descriptor 0, position 0.
- R10: After reset, all registers read 0, and the output valid, interrupt and memory request are low.
- R11: The stream tag output follows control bits 7:4.
- R12: Register word addresses: 0 control, 1 status, 2 list base low, 3 list base high, 4 ring length, 5 last index, 6 limit, 7 limit enable. The configuration registers read back the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for reg_addr |
| mem_req | output | 1 | Memory read request (one cycle) |
| mem_addr | output | AW | Memory byte address |
| mem_rvalid | input | 1 | Memory response valid |
| mem_rdata | input | DW | Memory response data |
| mem_rerr | input | 1 | Memory response error flag |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Output consumer ready |
| out_data | output | DW | Output word |
| out_sid | output | 4 | Stream tag from the control register |
| irq | output | 1 | Interrupt |

## Verification
The bench keeps a behavioural memory and a queue of expected words, and compares every output handshake with that queue. This catches an engine that skips the wrap back to descriptor 0, reads fragment words in the wrong order, or keeps a stale position across a restart. The limit is stepped forward, across the ring end, and then onto the engine's own position. A design that treats a reached limit as still open, wraps the position late, or does not grant a full lap gives the wrong word count at each stall. The timing of the completion interrupt is pinned to the cycle the last word of the flagged descriptor appears, so an interrupt raised one descriptor early or late fails. Overflow, zero-length and memory-error cases check that the right status bit sets, that run drops, and that no further request follows.

// File: rtl/dlc_pkg.sv
// Shared definitions for the descriptor-list cyclic reader.
// Assumes 32-bit register words and a 3-bit register word address.
package dlc_pkg;

    localparam logic [2:0] RA_CTRL  = 3'd0;
    localparam logic [2:0] RA_STAT  = 3'd1;
    localparam logic [2:0] RA_LBLO  = 3'd2;
    localparam logic [2:0] RA_LBHI  = 3'd3;
    localparam logic [2:0] RA_RLEN  = 3'd4;
    localparam logic [2:0] RA_LAST  = 3'd5;
    localparam logic [2:0] RA_LIM   = 3'd6;
    localparam logic [2:0] RA_LIMEN = 3'd7;

    // Control word layout: run in bit 0, enables in bits 1..3, tag in 7:4.
    typedef struct packed {
        logic [3:0] sid;
        logic       ie_derr;
        logic       ie_ferr;
        logic       ie_cmp;
        logic       run;
    } ctrl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DREQ,
        ST_DWAIT,
        ST_BREQ,
        ST_BWAIT
    } eng_st_e;

endpackage

// File: rtl/dlc_regs.sv
// Register bank for the cyclic reader: configuration, control and
// write-1-to-clear status, plus the interrupt combine.
// Assumes one register access per cycle; hardware status sets win over clears.
module dlc_regs
    import dlc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          set_cmp,
    input  logic          set_ferr,
    input  logic          set_derr,
    input  logic          run_clr,
    output ctrl_t         ctrl,
    output logic [2*DW-1:0] list_base,
    output logic [DW-1:0] ring_len,
    output logic [DW-1:0] last_idx,
    output logic [DW-1:0] lim,
    output logic          lim_en,
    output logic          lim_wr,
    output logic          irq
);

    ctrl_t         ctrl_q;
    logic [2:0]    sts_q;
    logic [DW-1:0] lblo_q, lbhi_q, rlen_q, last_q, lim_q;
    logic          limen_q;
    logic          wr_ctrl, wr_sts;

    assign wr_ctrl = reg_we && (reg_addr == RA_CTRL);
    assign wr_sts  = reg_we && (reg_addr == RA_STAT);
    assign lim_wr  = reg_we && (reg_addr == RA_LIM);

    // Control word: software writes it, the engine may drop the run bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[7:0]);
            if (run_clr) ctrl_q.run <= 1'b0;
        end
    end

    // Status: sticky hardware sets, software clears by writing ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else begin
            sts_q <= (sts_q & ~(wr_sts ? reg_wdata[2:0] : 3'b000))
                   | {set_derr, set_ferr, set_cmp};
        end
    end

    // Plain configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lblo_q  <= '0;
            lbhi_q  <= '0;
            rlen_q  <= '0;
            last_q  <= '0;
            lim_q   <= '0;
            limen_q <= 1'b0;
        end else if (reg_we) begin
            case (reg_addr)
                RA_LBLO:  lblo_q  <= reg_wdata;
                RA_LBHI:  lbhi_q  <= reg_wdata;
                RA_RLEN:  rlen_q  <= reg_wdata;
                RA_LAST:  last_q  <= reg_wdata;
                RA_LIM:   lim_q   <= reg_wdata;
                RA_LIMEN: limen_q <= reg_wdata[0];
                default: ;
            endcase
        end
    end

    // Read mux for the word address presented.
    always_comb begin
        case (reg_addr)
            RA_CTRL:  reg_rdata = DW'(ctrl_q);
            RA_STAT:  reg_rdata = DW'(sts_q);
            RA_LBLO:  reg_rdata = lblo_q;
            RA_LBHI:  reg_rdata = lbhi_q;
            RA_RLEN:  reg_rdata = rlen_q;
            RA_LAST:  reg_rdata = last_q;
            RA_LIM:   reg_rdata = lim_q;
            default:  reg_rdata = DW'(limen_q);
        endcase
    end

    assign ctrl      = ctrl_q;
    assign list_base = {lbhi_q, lblo_q};
    assign ring_len  = rlen_q;
    assign last_idx  = last_q;
    assign lim       = lim_q;
    assign lim_en    = limen_q;
    assign irq       = |(sts_q & {ctrl_q.ie_derr, ctrl_q.ie_ferr, ctrl_q.ie_cmp});

    AST_DERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        set_derr |=> !ctrl_q.run); // R7
    AST_W1C_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && reg_wdata[0] && !set_cmp) |=> !sts_q[0]); // R6

endmodule

// File: rtl/dlc_fifo.sv
// Small output FIFO between the read engine and the stream port.
// Assumes the caller never pops when empty and pushes into a full FIFO only
// together with a pop.
module dlc_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic          full,
    output logic          empty
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] store [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Data storage: written at the write pointer on each push.
    always_ff @(posedge clk) begin
        if (push) store[wp] <= wdata;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= ptr_next(wp);
            if (pop)  rp <= ptr_next(rp);
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign rdata = store[rp];
    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH)); // R8
    AST_FIFO_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |-> pop); // R8
    AST_FIFO_POP_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R1

endmodule

// File: rtl/dlc_engine.sv
// Read engine: fetches descriptors, reads fragment words one at a time,
// tracks the ring position and the limit gate, and flags completion and
// errors. Assumes fragment lengths are whole words and the memory answers
// each request with exactly one response.
module dlc_engine
    import dlc_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [2*DW-1:0] list_base,
    input  logic [DW-1:0]   ring_len,
    input  logic [DW-1:0]   last_idx,
    input  logic [DW-1:0]   lim,
    input  logic            lim_en,
    input  logic            lim_wr,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_rvalid,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_rerr,
    output logic            dat_vld,
    output logic [DW-1:0]   dat_word,
    output logic            set_cmp,
    output logic            set_derr
);

    localparam int LW  = 2 * DW;
    localparam int BPW = DW / 8;

    eng_st_e       st;
    logic [DW-1:0] idx, offs, pos, len_q;
    logic [LW-1:0] buf_addr;
    logic [1:0]    wsel;
    logic          ioc_q, armed;

    logic [DW-1:0] lim_mod, pos_inc, pos_nx;
    logic [LW-1:0] desc_addr, data_addr;
    logic          last_word, gate_ok, resp_ok, zero_len;

    // Next-position, limit and address arithmetic.
    always_comb begin
        lim_mod   = (lim >= ring_len) ? '0 : lim;
        pos_inc   = pos + DW'(BPW);
        pos_nx    = (pos_inc >= ring_len) ? '0 : pos_inc;
        last_word = (offs + DW'(BPW)) >= len_q;
        gate_ok   = !(lim_en && !armed);
        desc_addr = list_base + LW'({idx, 4'b0000}) + LW'({wsel, 2'b00});
        data_addr = buf_addr + LW'(offs);
        resp_ok   = mem_rvalid && !mem_rerr;
        zero_len  = (st == ST_DWAIT) && resp_ok && (wsel == 2'd2) && (mem_rdata == '0);
    end

    assign mem_req  = run && ((st == ST_DREQ) || ((st == ST_BREQ) && gate_ok));
    assign mem_addr = AW'((st == ST_DREQ) ? desc_addr : data_addr);
    assign dat_vld  = (st == ST_BWAIT) && resp_ok;
    assign dat_word = mem_rdata;
    assign set_cmp  = dat_vld && last_word && ioc_q;
    assign set_derr = zero_len ||
                      (((st == ST_DWAIT) || (st == ST_BWAIT)) && mem_rvalid && mem_rerr);

    // Sequencer: descriptor fetch, fragment reads, ring and list stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            idx      <= '0;
            offs     <= '0;
            pos      <= '0;
            len_q    <= '0;
            buf_addr <= '0;
            wsel     <= '0;
            ioc_q    <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (run) begin
                    idx  <= '0;
                    pos  <= '0;
                    wsel <= '0;
                    st   <= ST_DREQ;
                end
                ST_DREQ: st <= run ? ST_DWAIT : ST_IDLE;
                ST_DWAIT: if (mem_rvalid) begin
                    if (mem_rerr || zero_len) begin
                        st <= ST_IDLE;
                    end else begin
                        case (wsel)
                            2'd0:    buf_addr[DW-1:0]  <= mem_rdata;
                            2'd1:    buf_addr[LW-1:DW] <= mem_rdata;
                            2'd2:    len_q             <= mem_rdata;
                            default: ioc_q             <= mem_rdata[0];
                        endcase
                        wsel <= wsel + 2'd1;
                        offs <= '0;
                        st   <= (wsel == 2'd3) ? ST_BREQ : ST_DREQ;
                    end
                end
                ST_BREQ: begin
                    if (!run)         st <= ST_IDLE;
                    else if (gate_ok) st <= ST_BWAIT;
                end
                ST_BWAIT: if (mem_rvalid) begin
                    if (mem_rerr) begin
                        st <= ST_IDLE;
                    end else begin
                        pos <= pos_nx;
                        if (last_word) begin
                            idx  <= (idx >= last_idx) ? '0 : idx + 1'b1;
                            wsel <= '0;
                            st   <= ST_DREQ;
                        end else begin
                            offs <= offs + DW'(BPW);
                            st   <= ST_BREQ;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Limit gate: opened by a limit write, closed when the position meets it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (lim_wr) begin
            armed <= 1'b1;
        end else if (lim_en && dat_vld && (pos_nx == lim_mod)) begin
            armed <= 1'b0;
        end
    end

    AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R1
    AST_ZERO_LEN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        zero_len |=> (st == ST_IDLE) && !mem_req); // R7
    AST_STOP_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_BREQ) && !run) |=> (st == ST_IDLE)); // R9

endmodule

// File: rtl/dlc_reader.sv
// Top of the descriptor-list cyclic reader: register bank, read engine and
// output FIFO. A returning word that finds the FIFO full with the consumer
// stalled is dropped and reported as a FIFO error.
module dlc_reader
    import dlc_pkg::*;
#(
    parameter int DW         = 32,
    parameter int AW         = 32,
    parameter int FIFO_DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_rerr,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    output logic [3:0]    out_sid,
    output logic          irq
);

    ctrl_t           ctrl;
    logic [2*DW-1:0] list_base;
    logic [DW-1:0]   ring_len, last_idx, lim, dat_word;
    logic            lim_en, lim_wr, dat_vld, set_cmp, set_derr, set_ferr;
    logic            f_full, f_empty, f_push, f_pop, accept;

    dlc_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .set_cmp   (set_cmp),
        .set_ferr  (set_ferr),
        .set_derr  (set_derr),
        .run_clr   (set_derr),
        .ctrl      (ctrl),
        .list_base (list_base),
        .ring_len  (ring_len),
        .last_idx  (last_idx),
        .lim       (lim),
        .lim_en    (lim_en),
        .lim_wr    (lim_wr),
        .irq       (irq)
    );

    dlc_engine #(.DW(DW), .AW(AW)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (ctrl.run),
        .list_base  (list_base),
        .ring_len   (ring_len),
        .last_idx   (last_idx),
        .lim        (lim),
        .lim_en     (lim_en),
        .lim_wr     (lim_wr),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .mem_rerr   (mem_rerr),
        .dat_vld    (dat_vld),
        .dat_word   (dat_word),
        .set_cmp    (set_cmp),
        .set_derr   (set_derr)
    );

    // A word is taken when there is room or a word leaves in the same cycle.
    assign accept   = !f_full || out_ready;
    assign f_push   = dat_vld && accept;
    assign set_ferr = dat_vld && !accept;
    assign f_pop    = !f_empty && out_ready;

    dlc_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (f_push),
        .wdata (dat_word),
        .pop   (f_pop),
        .rdata (out_data),
        .full  (f_full),
        .empty (f_empty)
    );

    assign out_valid = !f_empty;
    assign out_sid   = ctrl.sid;

endmodule

// File: tb/dlc_reader_bench.sv
`timescale 1ns/1ps
module dlc_reader_bench;

    localparam int DW = 32;
    localparam int AW = 32;
    localparam int DEPTH = 4;
    localparam logic [31:0] LB = 32'h0000_1000;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          m_rvalid = 1'b0;
    logic [DW-1:0] m_rdata = '0;
    logic          m_rerr = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [DW-1:0] out_data;
    logic [3:0]    out_sid;
    logic          irq;

    dlc_reader #(.DW(DW), .AW(AW), .FIFO_DEPTH(DEPTH)) u_dlc_reader (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(m_rvalid), .mem_rdata(m_rdata),
        .mem_rerr(m_rerr), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_sid(out_sid), .irq(irq)
    );

    int errors = 0;
    int checks = 0;
    int popped = 0;
    int cyc = 0;
    logic [31:0] exp_q[$];
    logic [31:0] d_addr[3];
    logic [31:0] d_len[3];
    logic        d_ioc[3];
    logic [31:0] err_addr = 32'hFFFF_FFF0;
    logic        irq_watch = 1'b0;
    logic        irq_prev = 1'b0;
    logic [31:0] rv;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, a[15:0]};
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] rel;
        rel = a - LB;
        if (a >= LB && a < LB + 32'd48) begin
            case (rel[3:2])
                2'd0:    return d_addr[rel[5:4]];
                2'd1:    return 32'h0;
                2'd2:    return d_len[rel[5:4]];
                default: return {31'b0, d_ioc[rel[5:4]]};
            endcase
        end
        return pat(a);
    endfunction

    // Behavioural memory: answers every request one cycle later.
    always @(posedge clk) begin
        m_rvalid <= mem_req;
        m_rdata  <= mem_word(mem_addr);
        m_rerr   <= mem_req && (mem_addr == err_addr);
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-cycle comparison of the output stream and interrupt timing.
    always @(negedge clk) begin
        logic [31:0] e;
        cyc++;
        if (cyc > 100000) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
        if (rst_n && irq_watch && irq && !irq_prev)
            chk(out_valid && out_data == pat(32'h400C) && (popped % 9) == 3,
                "R5 irq with last word of flagged descriptor", out_data, pat(32'h400C));
        irq_prev = irq;
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1 unexpected word", out_data, 32'h0);
            end else begin
                e = exp_q.pop_front();
                chk(out_data == e, "R1 R2 stream word", out_data, e);
            end
            popped++;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_irq(input int n);
        for (int i = 0; i < n && !irq; i++) @(negedge clk);
    endtask

    task automatic count_req(input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (mem_req) hits++;
        end
    endtask

    task automatic build_q(input int laps);
        exp_q.delete();
        for (int l = 0; l < laps; l++)
            for (int i = 0; i < 3; i++)
                for (int k = 0; k < int'(d_len[i] / 4); k++)
                    exp_q.push_back(pat(d_addr[i] + 32'(4 * k)));
    endtask

    initial begin
        int hits;
        d_addr[0] = 32'h4000; d_len[0] = 16; d_ioc[0] = 1'b1;
        d_addr[1] = 32'h5000; d_len[1] = 8;  d_ioc[1] = 1'b0;
        d_addr[2] = 32'h6000; d_len[2] = 12; d_ioc[2] = 1'b0;

        cycles(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(!out_valid && !irq && !mem_req, "R10 outputs idle", {out_valid, irq, mem_req}, 0);
        rd(dlc_pkg::RA_STAT, rv); chk(rv == 0, "R10 status", rv, 0);
        rd(dlc_pkg::RA_CTRL, rv); chk(rv == 0, "R10 control", rv, 0);

        // R12: configuration readback
        wr(3'd2, LB);     rd(3'd2, rv); chk(rv == LB, "R12 list low", rv, LB);
        wr(3'd3, 32'h0);  rd(3'd3, rv); chk(rv == 0, "R12 list high", rv, 0);
        wr(3'd4, 32'd36); rd(3'd4, rv); chk(rv == 36, "R12 ring length", rv, 36);
        wr(3'd5, 32'd2);  rd(3'd5, rv); chk(rv == 2, "R12 last index", rv, 2);

        // R1 R2 R5 R6: two laps with completion interrupt on descriptor 0
        build_q(4);
        popped = 0;
        irq_watch = 1'b1;
        wr(3'd0, 32'h03);
        wait_irq(500);
        chk(irq, "R5 completion irq", irq, 1);
        wr(3'd1, 32'h1);
        chk(!irq, "R6 write-1-to-clear drops irq", irq, 0);
        for (int i = 0; i < 1000 && popped < 18; i++) @(negedge clk);
        chk(popped >= 18, "R2 two laps", popped, 18);
        wr(3'd0, 32'h0);
        cycles(10);
        count_req(20, hits);
        chk(hits == 0, "R9 no requests after stop", hits, 0);
        irq_watch = 1'b0;
        wr(3'd1, 32'h7);

        // R3 R4 R9: limit gate, wrap, full lap; restart from descriptor 0
        build_q(4);
        popped = 0;
        wr(3'd7, 32'h1);
        wr(3'd6, 32'd16);
        wr(3'd0, 32'h01);
        cycles(80);
        chk(popped == 4, "R4 R9 stop at limit 16", popped, 4);
        rd(3'd1, rv);
        chk(rv[0] == 1'b1 && !irq, "R6 status set, irq masked", {rv[0], irq}, 2'b10);
        wr(3'd6, 32'd28);
        cycles(80);
        chk(popped == 7, "R4 advance to 28", popped, 7);
        wr(3'd6, 32'd8);
        cycles(80);
        chk(popped == 11, "R3 wrap past ring end", popped, 11);
        wr(3'd6, 32'd8);
        cycles(120);
        chk(popped == 20, "R4 same position grants a lap", popped, 20);
        wr(3'd0, 32'h0);
        wr(3'd7, 32'h0);
        cycles(20);
        wr(3'd1, 32'h7);

        // R8 R9: overflow with stalled consumer
        build_q(4);
        popped = 0;
        out_ready = 1'b0;
        wr(3'd0, 32'h05);
        wait_irq(200);
        chk(irq, "R6 FIFO error irq", irq, 1);
        rd(3'd1, rv);
        chk(rv[1] == 1'b1, "R8 FIFO error status", rv, 32'h2);
        wr(3'd0, 32'h0);
        cycles(10);
        count_req(20, hits);
        chk(hits == 0, "R9 idle after stop", hits, 0);
        out_ready = 1'b1;
        cycles(20);
        chk(popped == 4, "R8 queued words kept", popped, 4);
        wr(3'd1, 32'h7);

        // R7: zero-length descriptor
        d_len[1] = 0;
        exp_q.delete();
        for (int k = 0; k < 4; k++) exp_q.push_back(pat(32'h4000 + 32'(4 * k)));
        popped = 0;
        wr(3'd0, 32'h09);
        wait_irq(300);
        chk(irq, "R7 zero length irq", irq, 1);
        rd(3'd0, rv);
        chk(rv[0] == 1'b0, "R7 run cleared", rv, 32'h08);
        count_req(20, hits);
        chk(hits == 0 && popped == 4, "R7 halted after zero length", hits, 0);
        wr(3'd1, 32'h7);
        d_len[1] = 8;

        // R7: memory error response
        err_addr = 32'h5004;
        exp_q.delete();
        for (int k = 0; k < 4; k++) exp_q.push_back(pat(32'h4000 + 32'(4 * k)));
        exp_q.push_back(pat(32'h5000));
        popped = 0;
        wr(3'd0, 32'h09);
        wait_irq(300);
        rd(3'd1, rv);
        chk(rv[2] == 1'b1, "R7 read error status", rv, 32'h4);
        rd(3'd0, rv);
        chk(rv[0] == 1'b0, "R7 run cleared on read error", rv, 32'h08);
        cycles(20);
        chk(popped == 5, "R7 words before error", popped, 5);
        err_addr = 32'hFFFF_FFF0;
        wr(3'd1, 32'h7);

        // R11: stream tag
        wr(3'd0, 32'hA0);
        @(negedge clk);
        chk(out_sid == 4'hA, "R11 stream tag", out_sid, 4'hA);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule